// File: doc/BRIEF.md
# Register-Driven Byte Access Engine for Parallel Flash

This block lets software reach an external parallel flash one byte at a time through two host registers on a simple register bus. A control register holds a byte address, a direction bit and a go/busy bit. A data register holds the byte to be written, or the byte that a read returned. When software sets the go bit while the engine is idle, the engine takes a copy of the address, the direction and the write byte. It then runs one flash cycle on the address, data, chip-enable, output-enable and write-enable pins, with timing that parameters set. On a read it stores the returned byte in the data register. Busy stays set until the cycle has ended, and software polls it.

To write, software waits for busy to clear, loads the data register, then writes the control register with the address, a cleared direction bit and the go bit. To read, software waits for busy to clear, writes the control register with the address, a set direction bit and the go bit, waits for busy to clear again, then reads the data register.

The register bus has no back-pressure: the block accepts a write in the cycle it is presented, and read data follows `bus_addr` combinationally. Status and control pins are plain levels; the block has no streaming interface.

Top module: `flash_regbus_engine`

## Requirements
- R1: In the control register (bus_addr 0), bits [18:0] hold the flash byte address and may be written while the engine is idle. Bits [23:19] and [31:26] always read 0, and writes to them have no effect.
- R2: The data register (bus_addr 1) holds one byte in bits [7:0]. Bits [31:8] read 0. Software may write the byte while the engine is idle.
- R3: Writing the control register with bit 25 set while idle starts one access. Bit 25 reads 1 from the next cycle until the access has finished, then reads 0.
- R4: Bit 24 of the control register selects the direction, 0 for a write and 1 for a read. During the access the flash address pins carry the address given at the start, and after the access the control register reads back that address and that direction.
- R5: A write access holds chip-enable low throughout. It drives the data bus for SETUP_CLKS cycles with write-enable high, then holds write-enable low for WE_CLKS cycles, then keeps the data bus driven for HOLD_CLKS cycles after write-enable rises. A final idle cycle follows, so busy lasts SETUP_CLKS+WE_CLKS+HOLD_CLKS+1 cycles (6 at the defaults).
- R6: A read access holds chip-enable and output-enable low for RD_CLKS cycles without driving the data bus. It samples the flash data in the last of those cycles into the data register, then releases both strobes for one cycle before busy clears, so busy lasts RD_CLKS+1 cycles (5 at the defaults).
- R7: While busy, writes to the address, direction and data fields are ignored. A further go request is discarded and never produces a second flash cycle.
- R8: A write access drives onto the flash data bus the data register value as it was when the go bit was written.
- R9: Reset, including reset in the middle of an access, clears busy and both registers, drives chip-enable, output-enable and write-enable high, and releases the flash data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write when high |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| fl_addr | output | 19 | Flash byte address |
| fl_dq_o | output | 8 | Byte driven toward the flash |
| fl_dq_i | input | 8 | Byte returned by the flash |
| fl_dq_oe | output | 1 | High while the block drives the data bus |
| fl_ce_n | output | 1 | Flash chip-enable, active low |
| fl_oe_n | output | 1 | Flash output-enable, active low |
| fl_we_n | output | 1 | Flash write-enable, active low |

## Verification
The assertions assume that software drives only register 0 or 1 and that it follows the poll-then-program order, so a go request is the only event that moves the sequencer out of idle. They also assume that the flash holds its data bus stable for the whole output-enable window. The bench drives every bus access half a cycle away from the sampling edge. Its flash model returns a stored byte whenever chip-enable and output-enable are both low, and it commits a byte only when write-enable rises. The one deliberate break of the polling order is a test that writes both registers while busy, to show those writes are ignored.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  localparam int BUS_W       = 32;
  localparam int CTRL_GO_BIT = 25;
  localparam int CTRL_RD_BIT = 24;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_WSETUP,
    FS_WPULSE,
    FS_WHOLD,
    FS_RACCESS,
    FS_DONE
  } fseq_state_t;
endpackage

// File: rtl/flash_eng_regs.sv
module flash_eng_regs
  import flash_eng_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             start_o,
  output logic [AW-1:0]    start_addr_o,
  output logic             start_rd_o,
  output logic [DW-1:0]    wr_byte_o,
  input  logic             done_i,
  input  logic             done_rd_i,
  input  logic [DW-1:0]    rd_byte_i
);
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic [DW-1:0] data_q;
  logic          wr_ctrl, wr_data;
  logic          wdata_unused;

  assign wr_ctrl = bus_sel && bus_we && !bus_addr;
  assign wr_data = bus_sel && bus_we && bus_addr;
  assign wdata_unused = ^{bus_wdata[BUS_W-1:CTRL_GO_BIT+1], bus_wdata[CTRL_RD_BIT-1:AW]};

  // A go request is honoured only while idle
  assign start_o      = wr_ctrl && bus_wdata[CTRL_GO_BIT] && !busy_q;
  assign start_addr_o = bus_wdata[AW-1:0];
  assign start_rd_o   = bus_wdata[CTRL_RD_BIT];
  assign wr_byte_o    = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      data_q <= '0;
    end else begin
      if (!busy_q) begin
        if (wr_ctrl) begin
          addr_q <= bus_wdata[AW-1:0];
          rd_q   <= bus_wdata[CTRL_RD_BIT];
        end
        if (wr_data) data_q <= bus_wdata[DW-1:0];
      end
      if (start_o)     busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
      if (done_i && done_rd_i) data_q <= rd_byte_i;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr) begin
      bus_rdata[AW-1:0]        = addr_q;
      bus_rdata[CTRL_RD_BIT]   = rd_q;
      bus_rdata[CTRL_GO_BIT]   = busy_q;
    end else begin
      bus_rdata[DW-1:0] = data_q;
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_o |=> busy_q); // R3
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_ctrl) |=> $stable(addr_q)); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_i) |=> $stable(data_q)); // R7
endmodule

// File: rtl/flash_eng_seq.sv
module flash_eng_seq
  import flash_eng_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int SETUP_CLKS = 1,
  parameter int WE_CLKS    = 3,
  parameter int HOLD_CLKS  = 1,
  parameter int RD_CLKS    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          start_rd_i,
  input  logic [DW-1:0] wr_byte_i,
  output logic          done_o,
  output logic          done_rd_o,
  output logic [DW-1:0] rd_byte_o,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_dq_oe,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int MAX_A = (SETUP_CLKS > WE_CLKS) ? SETUP_CLKS : WE_CLKS;
  localparam int MAX_B = (HOLD_CLKS > RD_CLKS) ? HOLD_CLKS : RD_CLKS;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] LD_WE    = CNT_W'(WE_CLKS - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CLKS - 1);
  localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_CLKS - 1);

  fseq_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    addr_q;
  logic             rd_q;
  logic [DW-1:0]    wbyte_q;
  logic [DW-1:0]    cap_q;
  logic             cnt_end;

  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wbyte_q <= '0;
      cap_q   <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (start_i) begin
          addr_q  <= start_addr_i;
          rd_q    <= start_rd_i;
          wbyte_q <= wr_byte_i;
          if (start_rd_i) begin
            state_q <= FS_RACCESS;
            cnt_q   <= LD_RD;
          end else begin
            state_q <= FS_WSETUP;
            cnt_q   <= LD_SETUP;
          end
        end
        FS_WSETUP: if (cnt_end) begin
          state_q <= FS_WPULSE;
          cnt_q   <= LD_WE;
        end else cnt_q <= cnt_q - 1'b1;
        FS_WPULSE: if (cnt_end) begin
          state_q <= FS_WHOLD;
          cnt_q   <= LD_HOLD;
        end else cnt_q <= cnt_q - 1'b1;
        FS_WHOLD: if (cnt_end) state_q <= FS_DONE;
                  else cnt_q <= cnt_q - 1'b1;
        FS_RACCESS: if (cnt_end) begin
          cap_q   <= fl_dq_i;
          state_q <= FS_DONE;
        end else cnt_q <= cnt_q - 1'b1;
        FS_DONE: state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  // Pin decode from the registered state
  logic in_write;
  assign in_write  = (state_q == FS_WSETUP) || (state_q == FS_WPULSE) || (state_q == FS_WHOLD);
  assign fl_ce_n   = !(in_write || (state_q == FS_RACCESS));
  assign fl_oe_n   = (state_q != FS_RACCESS);
  assign fl_we_n   = (state_q != FS_WPULSE);
  assign fl_dq_oe  = in_write;
  assign fl_dq_o   = wbyte_q;
  assign fl_addr   = addr_q;
  assign done_o    = (state_q == FS_DONE);
  assign done_rd_o = rd_q;
  assign rd_byte_o = cap_q;

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n); // R5
  AST_WE_DRIVES_DQ: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_dq_oe); // R5
  AST_DQ_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> fl_dq_oe); // R5
  AST_OE_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (!fl_dq_oe && fl_we_n)); // R6
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (state_q == FS_IDLE)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe)); // R9
endmodule

// File: rtl/flash_regbus_engine.sv
module flash_regbus_engine
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int SETUP_CLKS = 1,
  parameter int WE_CLKS    = 3,
  parameter int HOLD_CLKS  = 1,
  parameter int RD_CLKS    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  input  logic [DATA_W-1:0] fl_dq_i,
  output logic              fl_dq_oe,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic              start_rd;
  logic [DATA_W-1:0] wr_byte;
  logic              done;
  logic              done_rd;
  logic [DATA_W-1:0] rd_byte;

  flash_eng_regs #(.AW(ADDR_W), .DW(DATA_W)) i_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_o(start), .start_addr_o(start_addr), .start_rd_o(start_rd),
    .wr_byte_o(wr_byte),
    .done_i(done), .done_rd_i(done_rd), .rd_byte_i(rd_byte)
  );

  flash_eng_seq #(
    .AW(ADDR_W), .DW(DATA_W), .SETUP_CLKS(SETUP_CLKS),
    .WE_CLKS(WE_CLKS), .HOLD_CLKS(HOLD_CLKS), .RD_CLKS(RD_CLKS)
  ) i_seq (
    .clk(clk), .rst(rst),
    .start_i(start), .start_addr_i(start_addr), .start_rd_i(start_rd),
    .wr_byte_i(wr_byte),
    .done_o(done), .done_rd_o(done_rd), .rd_byte_o(rd_byte),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_i(fl_dq_i),
    .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );
endmodule

// File: tb/test_flash_regbus_engine.sv
`timescale 1ns/1ps
module test_flash_regbus_engine;
  localparam int SETUP = 1, WEP = 3, HOLD = 1, RDW = 4;
  localparam int WR_BUSY = SETUP + WEP + HOLD + 1;
  localparam int RD_BUSY = RDW + 1;
  localparam logic [31:0] GO = 32'h0200_0000;
  localparam logic [31:0] RDB = 32'h0100_0000;
  // {read, address[18:0], byte}
  localparam logic [27:0] VEC [8] = '{
    {1'b0, 19'h00012, 8'hA5}, {1'b0, 19'h7FF34, 8'h3C},
    {1'b0, 19'h00000, 8'h5A}, {1'b0, 19'h40056, 8'hFF},
    {1'b1, 19'h7FF34, 8'h3C}, {1'b1, 19'h00012, 8'hA5},
    {1'b1, 19'h40056, 8'hFF}, {1'b1, 19'h00000, 8'h5A}
  };

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_we = 0, bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [18:0] fl_addr;
  logic [7:0]  fl_dq_o, fl_dq_i;
  logic fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] fmem [256];
  int we_len = 0, acc_cnt = 0;
  logic [7:0] wcap;
  logic [18:0] waddr, last_waddr;
  logic prev_ce = 1;

  always #2 clk = ~clk;

  flash_regbus_engine i_flash_regbus_engine (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_i(fl_dq_i), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  assign fl_dq_i = (!fl_ce_n && !fl_oe_n) ? fmem[fl_addr[7:0]] : 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Flash model: commit a byte when write-enable rises
  always @(negedge clk) begin
    if (rst) begin
      we_len = 0;
      prev_ce = 1;
    end else begin
      if (prev_ce && !fl_ce_n) acc_cnt++;
      prev_ce = fl_ce_n;
      if (!fl_we_n) begin
        we_len++;
        wcap = fl_dq_o;
        waddr = fl_addr;
      end else if (we_len > 0) begin
        chk(we_len == WEP, "R5 we pulse width", we_len, WEP);
        chk(fl_dq_oe == 1'b1, "R5 data held after we rise", fl_dq_oe, 1);
        fmem[waddr[7:0]] = wcap;
        last_waddr = waddr;
        we_len = 0;
      end
    end
  end

  task automatic bwrite(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic bread(input logic a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 0;
  endtask

  task automatic run_access(output int cyc, output int oel, output logic lce,
                            output logic loe, output logic [18:0] fa);
    cyc = 0; oel = 0; lce = 0; loe = 0; fa = fl_addr;
    bus_addr = 0;
    #1;
    fa = fl_addr;
    while (bus_rdata[25] && cyc < 100) begin
      cyc++;
      lce = fl_ce_n; loe = fl_oe_n;
      if (!fl_oe_n) oel++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    logic [31:0] rv;
    logic vrd;
    logic [18:0] va, fa;
    logic [7:0] vd;
    int cyc, oel, a0;
    logic lce, loe;

    for (int i = 0; i < 256; i++) fmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R9 strobes idle after reset",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    bread(0, rv); chk(rv == 0, "R9 control reg reset", rv, 0);
    bread(1, rv); chk(rv == 0, "R9 data reg reset", rv, 0);

    // Vector walk: writes then reads back
    for (int i = 0; i < 8; i++) begin
      {vrd, va, vd} = VEC[i];
      if (!vrd) bwrite(1, {24'h0, vd});
      bwrite(0, GO | (vrd ? RDB : 32'h0) | {13'h0, va});
      run_access(cyc, oel, lce, loe, fa);
      chk(cyc > 0, "R3 busy set after go", cyc, 1);
      chk(fa == va, "R4 flash address pins", fa, va);
      bread(0, rv);
      chk(rv == ({6'h0, 1'b0, vrd, 5'h0, va}), "R3 R4 control readback after access",
          rv, {6'h0, 1'b0, vrd, 5'h0, va});
      if (!vrd) begin
        chk(cyc == WR_BUSY, "R5 write busy length", cyc, WR_BUSY);
        chk(fmem[va[7:0]] == vd, "R5 byte stored in flash", fmem[va[7:0]], vd);
        chk(last_waddr == va, "R4 write address", last_waddr, va);
      end else begin
        chk(cyc == RD_BUSY, "R6 read busy length", cyc, RD_BUSY);
        chk(oel == RDW, "R6 output-enable window", oel, RDW);
        chk(lce && loe, "R6 strobes released before busy clears", {lce, loe}, 2'b11);
        bread(1, rv);
        chk(rv == {24'h0, vd}, "R6 read byte in data reg", rv, vd);
      end
    end

    // R1 R2 undefined bits
    bwrite(0, 32'hFCFF_FFFF);
    bread(0, rv); chk(rv == 32'h0007_FFFF, "R1 undefined control bits", rv, 32'h0007_FFFF);
    bwrite(1, 32'hFFFF_FFFF);
    bread(1, rv); chk(rv == 32'h0000_00FF, "R2 data reg upper bits", rv, 32'hFF);

    // R7 R8 writes while busy are ignored
    bwrite(1, 32'h11);
    a0 = acc_cnt;
    bwrite(0, GO | 32'h77);
    bwrite(1, 32'h99);
    bwrite(0, GO | RDB | 32'h88);
    run_access(cyc, oel, lce, loe, fa);
    chk(fmem[8'h77] == 8'h11, "R8 byte latched at go", fmem[8'h77], 8'h11);
    bread(0, rv); chk(rv == 32'h77, "R7 control unchanged by busy writes", rv, 32'h77);
    bread(1, rv); chk(rv == 32'h11, "R7 data unchanged by busy write", rv, 32'h11);
    repeat (10) @(negedge clk);
    chk(acc_cnt == a0 + 1, "R7 second go discarded", acc_cnt, a0 + 1);
    chk(fl_ce_n == 1'b1, "R7 engine idle", fl_ce_n, 1);

    // R9 reset in the middle of a write pulse
    bwrite(1, 32'h42);
    bwrite(0, GO | 32'h100);
    @(negedge clk); #1;
    chk(fl_we_n == 1'b0, "R5 we low in pulse", fl_we_n, 0);
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    #1;
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R9 strobes idle after mid reset",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    bread(0, rv); chk(rv == 0, "R9 busy cleared by reset", rv, 0);
    bread(1, rv); chk(rv == 0, "R9 data cleared by reset", rv, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule